// File: doc/BRIEF.md
# Critical-Path Timing-Miss Injector for Single-Precision Multiply and Add

This stage sits after a single-precision multiply or add and corrupts the finished result the way a late critical wire does when the supply voltage is lowered. It does not flip independent output bits. It recomputes the one internal signal on the slowest path of the operation and keeps the value that signal had in the previous operation of the same kind. A miss does damage only when that signal had to change. In that case the stage returns the correct result with its exponent moved, so the whole value is scaled by a power of two.

The caller supplies both operands, the operation kind, the exact result and a miss strobe. The strobe can come from any random source compared against a miss rate. One cycle later the stage returns the result, either unchanged or scaled.

Top module: `fp32_critbit_injector`

## Requirements
- R1: `out_valid` is low after reset and equals `in_valid` delayed by one clock. `out_res` is the registered result of the operation presented in that earlier cycle.
- R2: When `in_miss` is 0, `out_res` equals `in_res`.
- R3: Multiply (`in_op`=0) uses bit 47 of the 48-bit product of the two 24-bit significands, each with its hidden 1 prepended. On a miss, if that bit rose from 0 to 1 since the previous multiply, the exponent field gains 1. If it fell from 1 to 0, the exponent field loses 1.
- R4: A miss on an operation whose critical signal equals its stored previous value leaves `in_res` unchanged.
- R5: Add (`in_op`=1) is classed by the operand signs and by the exponent difference. Equal signs give the same-sign class. Unequal signs with a difference above 1 give the far class. Unequal signs with a difference of 0 or 1 give the close class.
- R6: In the same-sign class, the critical signal is the carry out of the 24-bit significand sum, taken after the smaller operand is shifted right by the exponent difference. On a miss, a rising carry adds 1 to the exponent field and a falling carry subtracts 1.
- R7: In the far class, the critical signal is bit 23 of the 24-bit aligned significand difference. On a miss, a rise adds 1 to the exponent field and a fall subtracts 1.
- R8: In the close class, the critical signal is the leading-zero count of the 24-bit difference (24 when the difference is zero). On a miss, the exponent field changes by the new count minus the stored count.
- R9: Four separate history registers hold the multiply bit, the carry, the far-class top bit and the zero count. Each resets to 0. Each updates on every valid operation of its own class, whether or not a miss occurs.
- R10: The sign bit and the 23 fraction bits of `in_res` are never altered.
- R11: An adjusted exponent field is clamped to the range 1 to 254. A result whose exponent field is 0 or 255 passes unchanged.
- R12: While `in_valid` is low, no history register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 1 | 0 = multiply, 1 = add |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_res | input | 32 | Exact result |
| in_miss | input | 1 | Timing miss strobe |
| out_valid | output | 1 | Result valid |
| out_res | output | 32 | Possibly scaled result |

## Verification
The hardest case to reach is a miss whose effect depends on history. The same stimulus gives a different answer depending on which earlier operations of the same class came before it. The close class is the extreme case, because its scale factor is the difference of two leading-zero counts. The stimulus therefore builds this history deliberately with chosen operand pairs. A zero difference sets the stored count to 24, and the following close subtraction then produces a downward scale of 22 binades. Multiplies are interleaved between add operations to show that each class keeps its own history.

// File: rtl/fp32_critbit_injector.sv
module fp32_critbit_injector (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_op,
  input  logic [31:0] in_a,
  input  logic [31:0] in_b,
  input  logic [31:0] in_res,
  input  logic        in_miss,
  output logic        out_valid,
  output logic [31:0] out_res
);
  function automatic logic [4:0] lzc24(input logic [23:0] v);
    logic [4:0] n;
    logic       hit;
    n = 5'd0;
    hit = 1'b0;
    for (int i = 23; i >= 0; i--) begin
      if (v[i]) hit = 1'b1;
      else if (!hit) n = n + 5'd1;
    end
    return n;
  endfunction

  logic [7:0]  ea, eb, ebig, esml, ediff, eres;
  logic [23:0] ma, mb, mbig, msml, mshift, mdiff;
  logic [24:0] msum;
  logic [47:0] prod;
  logic        a_big, same_sgn, far_cls, close_cls;
  logic        crit_mul, crit_carry, crit_far;
  logic [4:0]  crit_nlz;
  logic        prev_mul, prev_carry, prev_far;
  logic [4:0]  prev_nlz;
  logic        changed, special, inject;
  logic signed [5:0] delta;
  logic signed [9:0] eadj;
  logic [7:0]  eclamp;

  assign ea = in_a[30:23];
  assign eb = in_b[30:23];
  assign ma = {1'b1, in_a[22:0]};
  assign mb = {1'b1, in_b[22:0]};

  assign prod     = 48'(ma) * 48'(mb);
  assign crit_mul = prod[47];

  assign a_big     = (ea > eb) || ((ea == eb) && (ma >= mb));
  assign ebig      = a_big ? ea : eb;
  assign esml      = a_big ? eb : ea;
  assign mbig      = a_big ? ma : mb;
  assign msml      = a_big ? mb : ma;
  assign ediff     = ebig - esml;
  assign mshift    = (ediff >= 8'd24) ? 24'd0 : (msml >> ediff);
  assign msum      = {1'b0, mbig} + {1'b0, mshift};
  assign mdiff     = mbig - mshift;
  assign same_sgn  = in_a[31] == in_b[31];
  assign far_cls   = !same_sgn && (ediff > 8'd1);
  assign close_cls = !same_sgn && (ediff <= 8'd1);

  assign crit_carry = msum[24];
  assign crit_far   = mdiff[23];
  assign crit_nlz   = lzc24(mdiff);

  always_comb begin
    changed = 1'b0;
    delta   = 6'sd0;
    if (!in_op) begin
      changed = crit_mul != prev_mul;
      delta   = crit_mul ? 6'sd1 : -6'sd1;
    end else if (same_sgn) begin
      changed = crit_carry != prev_carry;
      delta   = crit_carry ? 6'sd1 : -6'sd1;
    end else if (far_cls) begin
      changed = crit_far != prev_far;
      delta   = crit_far ? 6'sd1 : -6'sd1;
    end else begin
      changed = crit_nlz != prev_nlz;
      delta   = $signed({1'b0, crit_nlz}) - $signed({1'b0, prev_nlz});
    end
  end

  assign eres    = in_res[30:23];
  assign special = (eres == 8'd0) || (eres == 8'hFF);
  assign inject  = in_miss && changed && !special;
  assign eadj    = $signed({2'b00, eres}) + 10'(delta);
  assign eclamp  = (eadj < 10'sd1)   ? 8'd1   :
                   (eadj > 10'sd254) ? 8'd254 : eadj[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_mul   <= 1'b0;
      prev_carry <= 1'b0;
      prev_far   <= 1'b0;
      prev_nlz   <= 5'd0;
      out_valid  <= 1'b0;
      out_res    <= 32'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res <= inject ? {in_res[31], eclamp, in_res[22:0]} : in_res;
        if (!in_op)          prev_mul   <= crit_mul;
        else if (same_sgn)   prev_carry <= crit_carry;
        else if (far_cls)    prev_far   <= crit_far;
        else if (close_cls)  prev_nlz   <= crit_nlz;
      end
    end
  end
endmodule

module fp32_critbit_injector_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_op,
  input logic [31:0] in_a,
  input logic [31:0] in_b,
  input logic [31:0] in_res,
  input logic        in_miss,
  input logic        out_valid,
  input logic [31:0] out_res
);
  a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));
  a_r2_no_miss_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_miss) |=> out_res == $past(in_res));
  a_r10_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_res[31] == $past(in_res[31]));
  a_r10_fraction_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_res[22:0] == $past(in_res[22:0]));
  a_r11_exp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_res[30:23] != 8'd0 && in_res[30:23] != 8'hFF)
      |=> (out_res[30:23] != 8'd0 && out_res[30:23] != 8'hFF));
  a_r11_special_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_res[30:23] == 8'd0 || in_res[30:23] == 8'hFF))
      |=> out_res == $past(in_res));
endmodule

bind fp32_critbit_injector fp32_critbit_injector_chk chk (.*);

// File: tb/tb_fp32_critbit_injector.sv
module tb_fp32_critbit_injector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_op = 1'b0;
  logic [31:0] in_a = '0, in_b = '0, in_res = '0;
  logic        in_miss = 1'b0;
  logic        out_valid;
  logic [31:0] out_res;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  fp32_critbit_injector dut (.*);

  localparam int NV = 16;
  // {op, a, b, res, miss, expected}
  localparam logic [129:0] VEC [NV] = '{
    {1'b0, 32'h3FC00000, 32'h3FC00000, 32'h40100000, 1'b0, 32'h40100000}, // R2
    {1'b0, 32'h3F800000, 32'h3F800000, 32'h3F800000, 1'b1, 32'h3F000000}, // R3 fall
    {1'b0, 32'h3FC00000, 32'h3FC00000, 32'h40100000, 1'b1, 32'h40900000}, // R3 rise
    {1'b0, 32'h3FC00000, 32'h3FC00000, 32'h40100000, 1'b1, 32'h40100000}, // R4
    {1'b1, 32'h3F800000, 32'h3F800000, 32'h40000000, 1'b1, 32'h40800000}, // R6 rise
    {1'b1, 32'h3F800000, 32'h3F000000, 32'h3FC00000, 1'b1, 32'h3F400000}, // R6 fall
    {1'b1, 32'h3FE00000, 32'hBE800000, 32'h3FC00000, 1'b1, 32'h40400000}, // R7 rise, R5
    {1'b1, 32'h3F800000, 32'hBE800000, 32'h3F400000, 1'b1, 32'h3EC00000}, // R7 fall
    {1'b1, 32'h3F800000, 32'hBF400000, 32'h3E800000, 1'b1, 32'h3F800000}, // R8 +2, R5
    {1'b1, 32'h3F800000, 32'hBF800000, 32'h00000000, 1'b1, 32'h00000000}, // R11 zero
    {1'b1, 32'h3F800000, 32'hBF400000, 32'h3E800000, 1'b1, 32'h33800000}, // R8 -22
    {1'b0, 32'h3F800000, 32'h3F800000, 32'h3F800000, 1'b0, 32'h3F800000}, // R2
    {1'b0, 32'h3FC00000, 32'h3FC00000, 32'h7F000000, 1'b1, 32'h7F000000}, // R11 top
    {1'b0, 32'h3F800000, 32'h3F800000, 32'h00800000, 1'b1, 32'h00800000}, // R11 bottom
    {1'b0, 32'h3FC00000, 32'h3FC00000, 32'hC0123456, 1'b1, 32'hC0923456}, // R10
    {1'b1, 32'h3F800000, 32'h3F800000, 32'h40000000, 1'b1, 32'h40800000}  // R9
  };
  localparam string TAG [NV] = '{"R2","R3","R3","R4","R6","R6","R7","R7",
                                  "R8","R11","R8","R2","R11","R11","R10","R9"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic op, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] r, input logic m);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_res = r; in_miss = m;
    @(posedge clk); #1;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset data", out_res, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][129], VEC[i][128:97], VEC[i][96:65], VEC[i][64:33], VEC[i][32]);
      check($sformatf("%s vec%0d", TAG[i], i), out_res, VEC[i][31:0]);
      check("R1 valid", {31'd0, out_valid}, 32'd1);
    end

    // R12: multiply history is 1; an idle cycle carrying a bit-47=0 pair must not update it
    @(negedge clk);
    in_valid = 1'b0; in_op = 1'b0; in_a = 32'h3F800000; in_b = 32'h3F800000;
    in_res = 32'h3F800000; in_miss = 1'b1;
    @(posedge clk); #1;
    check("R1 valid low", {31'd0, out_valid}, 32'd0);
    apply(1'b0, 32'h3FC00000, 32'h3FC00000, 32'h40100000, 1'b1);
    check("R12 idle ignored", out_res, 32'h40100000);

    // R9: reset clears history, so bit 47 = 1 is now a rise
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    apply(1'b0, 32'h3FC00000, 32'h3FC00000, 32'h40100000, 1'b1);
    check("R9 reset history", out_res, 32'h40900000);

    // R8 close class with exponent difference 1 and sign of result kept (R10)
    apply(1'b1, 32'hBF800000, 32'h3F400000, 32'hBE800000, 1'b1);
    check("R8 close neg", out_res, 32'hBF800000);

    @(negedge clk); in_valid = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule